// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block remembers recent virtual-to-physical page translations for 4 KB pages so that a repeated access can be translated without walking the page tables. A lookup port is purely combinational. It takes a 32-bit virtual address and returns three things in the same cycle: a hit flag, the physical address, and the write and user permission bits of the page.

When a table walk finishes elsewhere, the walker writes the result through the fill port. The storage has four ways, and each way holds sixteen sets. A fill that finds a free way uses it. Once a set is full, a round-robin pointer kept for each set chooses which entry is replaced.

Each time the page directory base register is written, the flush input is pulsed. The pulse drops every cached translation in a single cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, every lookup misses. On any miss, `lk_paddr`, `lk_wr` and `lk_usr` are all zero.
- R2: A hit returns the stored physical page in `lk_paddr[31:12]`, joined with `lk_vaddr[11:0]` in the low bits. It also returns the stored write bit on `lk_wr` and the stored user bit on `lk_usr`.
- R3: Virtual address bits 15:12 (virtual page number bits 3:0) select the set, and bits 31:16 form the tag. Pages that differ only in their tag live together in one set. Pages with a different set field never share storage.
- R4: A fill is written on the clock edge. It is visible to lookups from the next cycle on, and not during the cycle in which it is presented.
- R5: A fill into a set that has invalid ways uses the lowest-numbered invalid way and displaces no valid entry.
- R6: A fill into a full set replaces the way named by that set's round-robin pointer, which starts at way 0. The pointer then advances by one, modulo 4. Each set has its own pointer.
- R7: A fill whose virtual page already has a valid entry overwrites that entry in place. It creates no second copy and does not move the pointer.
- R8: A flush pulse invalidates every entry, so all lookups miss from the next cycle.
- R9: When flush and fill are asserted in the same cycle, the flush wins and the fill is discarded.
- R10: Reset and flush return every round-robin pointer to way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 32 | Translated physical address (zero on miss) |
| lk_wr | output | 1 | Page writable (zero on miss) |
| lk_usr | output | 1 | Page user-accessible (zero on miss) |
| fl_en | input | 1 | Write a walk result this cycle |
| fl_vpn | input | 20 | Virtual page number of the fill |
| fl_ppn | input | 20 | Physical page number of the fill |
| fl_wr | input | 1 | Writable attribute of the fill |
| fl_usr | input | 1 | User attribute of the fill |
| flush | input | 1 | Invalidate all entries (directory base written) |

## Verification
The bench fills a single set past its capacity and then checks which virtual page disappeared. A replacement policy that ignored invalid ways would keep overwriting way 0. A pointer shared by all sets would evict the wrong page in the second set.

Refilling a page that is already cached must not evict anything. A design that allocated a duplicate would lose an unrelated page early and would later return a stale physical page.

A flush on the same cycle as a fill is checked to leave no entry behind. The order of evictions after a flush shows whether the pointers were reset: a retained pointer would evict the third page filled instead of the first.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic wr;
    logic usr;
  } tlb_attr_t;
endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 16,
  parameter int PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  tlb_attr_t        wr_attr,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_match,
  output logic [PPN_W-1:0] lk_ppn,
  output tlb_attr_t        lk_attr,
  output logic             fl_valid,
  output logic             fl_match
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_mem  [SETS];
  logic [PPN_W-1:0] ppn_mem  [SETS];
  tlb_attr_t        attr_mem [SETS];

  // Valid bits live in flops so a flush clears them in one cycle.
  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (we)      valid_q[wr_idx] <= 1'b1;
  end

  // Payload arrays carry no reset, so they can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[wr_idx]  <= wr_tag;
      ppn_mem[wr_idx]  <= wr_ppn;
      attr_mem[wr_idx] <= wr_attr;
    end
  end

  assign lk_match = valid_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign lk_ppn   = ppn_mem[lk_idx];
  assign lk_attr  = attr_mem[lk_idx];
  assign fl_valid = valid_q[wr_idx];
  assign fl_match = valid_q[wr_idx] && (tag_mem[wr_idx] == wr_tag);
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fill_go,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [WAYS-1:0]  way_valid,
  input  logic [WAYS-1:0]  way_match,
  output logic [WAYS-1:0]  victim
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] ptr_q [SETS];
  logic             any_match;
  logic             set_full;

  assign any_match = |way_match;
  assign set_full  = &way_valid;

  always_comb begin
    victim = '0;
    if (any_match) begin
      victim = way_match;
    end else if (!set_full) begin
      // Walk downwards so the lowest-numbered invalid way is chosen last.
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!way_valid[w]) begin
          victim    = '0;
          victim[w] = 1'b1;
        end
      end
    end else begin
      victim[ptr_q[fill_idx]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (fill_go && !any_match && set_full) begin
      ptr_q[fill_idx] <= ptr_q[fill_idx] + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PG_OFF = 12,
  parameter int WAYS   = 4,
  parameter int SETS   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [VA_W-1:0]        lk_vaddr,
  output logic                   lk_hit,
  output logic [PA_W-1:0]        lk_paddr,
  output logic                   lk_wr,
  output logic                   lk_usr,
  input  logic                   fl_en,
  input  logic [VA_W-PG_OFF-1:0] fl_vpn,
  input  logic [PA_W-PG_OFF-1:0] fl_ppn,
  input  logic                   fl_wr,
  input  logic                   fl_usr,
  input  logic                   flush
);
  localparam int IDX_W = $clog2(SETS);
  localparam int VPN_W = VA_W - PG_OFF;
  localparam int PPN_W = PA_W - PG_OFF;
  localparam int TAG_W = VPN_W - IDX_W;

  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] lk_idx, fl_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic             fill_go;
  tlb_attr_t        fl_attr;

  logic [WAYS-1:0]  hit_vec, way_valid, way_match, victim;
  logic [PPN_W-1:0] way_ppn  [WAYS];
  tlb_attr_t        way_attr [WAYS];

  assign lk_vpn  = lk_vaddr[VA_W-1:PG_OFF];
  assign lk_idx  = lk_vpn[IDX_W-1:0];
  assign lk_tag  = lk_vpn[VPN_W-1:IDX_W];
  assign fl_idx  = fl_vpn[IDX_W-1:0];
  assign fl_tag  = fl_vpn[VPN_W-1:IDX_W];
  assign fill_go = fl_en && !flush;   // flush wins over a same-cycle fill
  assign fl_attr = '{wr: fl_wr, usr: fl_usr};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)
    ) u_way (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .we       (fill_go && victim[w]),
      .wr_idx   (fl_idx),
      .wr_tag   (fl_tag),
      .wr_ppn   (fl_ppn),
      .wr_attr  (fl_attr),
      .lk_idx   (lk_idx),
      .lk_tag   (lk_tag),
      .lk_match (hit_vec[w]),
      .lk_ppn   (way_ppn[w]),
      .lk_attr  (way_attr[w]),
      .fl_valid (way_valid[w]),
      .fl_match (way_match[w])
    );
  end

  tlb_repl #(
    .WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W)
  ) u_repl (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .fill_go   (fill_go),
    .fill_idx  (fl_idx),
    .way_valid (way_valid),
    .way_match (way_match),
    .victim    (victim)
  );

  logic [PPN_W-1:0] ppn_sel;
  tlb_attr_t        attr_sel;

  // AND-OR mux over the one-hot hit vector; all zero on a miss.
  always_comb begin
    ppn_sel  = '0;
    attr_sel = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        ppn_sel  = ppn_sel | way_ppn[w];
        attr_sel = attr_sel | way_attr[w];
      end
    end
  end

  assign lk_hit   = |hit_vec;
  assign lk_paddr = lk_hit ? {ppn_sel, lk_vaddr[PG_OFF-1:0]} : '0;
  assign lk_wr    = attr_sel.wr;
  assign lk_usr   = attr_sel.usr;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PG_OFF = 12,
  parameter int WAYS   = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [VA_W-1:0]        lk_vaddr,
  input logic                   lk_hit,
  input logic [PA_W-1:0]        lk_paddr,
  input logic                   lk_wr,
  input logic                   lk_usr,
  input logic                   fl_en,
  input logic [VA_W-PG_OFF-1:0] fl_vpn,
  input logic [PA_W-PG_OFF-1:0] fl_ppn,
  input logic                   flush,
  input logic [WAYS-1:0]        hit_vec
);
  p_miss_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_paddr == '0 && !lk_wr && !lk_usr));

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_paddr[PG_OFF-1:0] == lk_vaddr[PG_OFF-1:0]);

  p_fill_seen_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fl_en) && !$past(flush) && !flush &&
     lk_vaddr[VA_W-1:PG_OFF] == $past(fl_vpn))
    |-> (lk_hit && lk_paddr[PA_W-1:PG_OFF] == $past(fl_ppn)));

  p_single_copy_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit);
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PG_OFF(PG_OFF), .WAYS(WAYS)
) u_chk (
  .clk(clk), .rst(rst), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
  .lk_paddr(lk_paddr), .lk_wr(lk_wr), .lk_usr(lk_usr), .fl_en(fl_en),
  .fl_vpn(fl_vpn), .fl_ppn(fl_ppn), .flush(flush), .hit_vec(hit_vec)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_wr, lk_usr;
  logic [31:0] lk_paddr;
  logic        fl_en = 1'b0;
  logic [19:0] fl_vpn = '0, fl_ppn = '0;
  logic        fl_wr = 1'b0, fl_usr = 1'b0;
  logic        flush = 1'b0;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;

  tlb_xlate i_tlb_xlate (
    .clk(clk), .rst(rst), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .lk_wr(lk_wr), .lk_usr(lk_usr), .fl_en(fl_en),
    .fl_vpn(fl_vpn), .fl_ppn(fl_ppn), .fl_wr(fl_wr), .fl_usr(fl_usr),
    .flush(flush)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // Lookup: drive the address after the falling edge, then sample.
  task automatic look(string req, logic [19:0] vpn, logic [11:0] off,
                      logic hit, logic [19:0] ppn, logic wr, logic usr);
    @(negedge clk);
    lk_vaddr = {vpn, off};
    #1;
    chk(req, "hit", {31'd0, lk_hit}, {31'd0, hit});
    chk(req, "paddr", lk_paddr, hit ? {ppn, off} : 32'd0);
    chk(req, "attr", {30'd0, lk_wr, lk_usr}, hit ? {30'd0, wr, usr} : 32'd0);
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic wr, logic usr);
    @(negedge clk);
    fl_en = 1'b1; fl_vpn = vpn; fl_ppn = ppn; fl_wr = wr; fl_usr = usr;
    @(negedge clk);
    fl_en = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  function automatic logic [19:0] pg(int tag, int set);
    return 20'((tag << 4) | set);
  endfunction

  task automatic t_reset();
    look("R1", 20'h00000, 12'h000, 1'b0, '0, 1'b0, 1'b0);
    look("R1", 20'hFFFFF, 12'hFFF, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_basic();
    // R4: the entry must not be visible during its own fill cycle.
    @(negedge clk);
    fl_en = 1'b1; fl_vpn = 20'h12345; fl_ppn = 20'hABCDE; fl_wr = 1'b1; fl_usr = 1'b0;
    lk_vaddr = 32'h12345678;
    #1;
    chk("R4", "hit during fill", {31'd0, lk_hit}, 32'd0);
    @(negedge clk);
    fl_en = 1'b0;
    #1;
    chk("R4", "hit after fill", {31'd0, lk_hit}, 32'd1);
    look("R2", 20'h12345, 12'h678, 1'b1, 20'hABCDE, 1'b1, 1'b0);
    look("R2", 20'h12345, 12'hFFF, 1'b1, 20'hABCDE, 1'b1, 1'b0);
    fill(20'h00042, 20'h00B88, 1'b0, 1'b1);
    look("R2", 20'h00042, 12'h00C, 1'b1, 20'h00B88, 1'b0, 1'b1);
  endtask

  task automatic t_index();
    do_flush();
    fill(20'h10003, 20'h00111, 1'b1, 1'b1);
    fill(20'h20003, 20'h00222, 1'b0, 1'b0);
    look("R3", 20'h10003, 12'h004, 1'b1, 20'h00111, 1'b1, 1'b1);
    look("R3", 20'h20003, 12'h008, 1'b1, 20'h00222, 1'b0, 1'b0);
    look("R3", 20'h10004, 12'h000, 1'b0, '0, 1'b0, 1'b0);
    look("R3", 20'h30003, 12'h000, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_replace();
    do_flush();
    for (int k = 1; k <= 4; k++) fill(pg(k, 7), 20'(16'h700 + k), 1'b1, 1'b0);
    for (int k = 1; k <= 4; k++) look("R5", pg(k, 7), 12'h010, 1'b1, 20'(16'h700 + k), 1'b1, 1'b0);
    fill(pg(5, 7), 20'h00705, 1'b1, 1'b0);
    look("R6", pg(1, 7), 12'h0, 1'b0, '0, 1'b0, 1'b0);
    look("R6", pg(2, 7), 12'h0, 1'b1, 20'h00702, 1'b1, 1'b0);
    look("R6", pg(5, 7), 12'h0, 1'b1, 20'h00705, 1'b1, 1'b0);
    fill(pg(6, 7), 20'h00706, 1'b1, 1'b0);
    look("R6", pg(2, 7), 12'h0, 1'b0, '0, 1'b0, 1'b0);
    look("R6", pg(3, 7), 12'h0, 1'b1, 20'h00703, 1'b1, 1'b0);
    // Set 8 has its own pointer, starting from way 0.
    for (int k = 1; k <= 5; k++) fill(pg(k, 8), 20'(16'h800 + k), 1'b0, 1'b1);
    look("R6", pg(1, 8), 12'h0, 1'b0, '0, 1'b0, 1'b0);
    look("R6", pg(2, 8), 12'h0, 1'b1, 20'h00802, 1'b0, 1'b1);
    look("R6", pg(3, 7), 12'h0, 1'b1, 20'h00703, 1'b1, 1'b0);
  endtask

  task automatic t_flush_ptr();
    // The set 7 pointer now stands at way 2; a flush must return it to way 0.
    do_flush();
    look("R8", pg(3, 7), 12'h0, 1'b0, '0, 1'b0, 1'b0);
    look("R8", pg(2, 8), 12'h0, 1'b0, '0, 1'b0, 1'b0);
    for (int k = 1; k <= 5; k++) fill(pg(k, 7), 20'(16'h900 + k), 1'b0, 1'b0);
    look("R10", pg(1, 7), 12'h0, 1'b0, '0, 1'b0, 1'b0);
    look("R10", pg(3, 7), 12'h0, 1'b1, 20'h00903, 1'b0, 1'b0);
  endtask

  task automatic t_refill();
    do_flush();
    for (int k = 1; k <= 4; k++) fill(pg(k, 2), 20'(16'h200 + k), 1'b0, 1'b0);
    fill(pg(2, 2), 20'h00999, 1'b1, 1'b1);
    look("R7", pg(2, 2), 12'h0, 1'b1, 20'h00999, 1'b1, 1'b1);
    look("R7", pg(1, 2), 12'h0, 1'b1, 20'h00201, 1'b0, 1'b0);
    fill(pg(5, 2), 20'h00205, 1'b0, 1'b0);
    look("R7", pg(1, 2), 12'h0, 1'b0, '0, 1'b0, 1'b0);
    fill(pg(6, 2), 20'h00206, 1'b0, 1'b0);
    look("R7", pg(2, 2), 12'h0, 1'b0, '0, 1'b0, 1'b0);
    look("R7", pg(3, 2), 12'h0, 1'b1, 20'h00203, 1'b0, 1'b0);
  endtask

  task automatic t_collide();
    fill(20'h0ABC1, 20'h00C01, 1'b1, 1'b0);
    @(negedge clk);
    flush = 1'b1; fl_en = 1'b1; fl_vpn = 20'h0ABC2; fl_ppn = 20'h00C02;
    @(negedge clk);
    flush = 1'b0; fl_en = 1'b0;
    look("R9", 20'h0ABC2, 12'h0, 1'b0, '0, 1'b0, 1'b0);
    look("R9", 20'h0ABC1, 12'h0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_index();
    t_replace();
    t_flush_ptr();
    t_refill();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule